// File: doc/BRIEF.md
# Switch Contact Debouncer

This block takes the raw level of a mechanical switch and gives a clean, settled copy of it. Contacts bounce for milliseconds, and logic clocked every few tens of nanoseconds would see each bounce as a new event. The block therefore accepts a new level only after the input has held it for a fixed window of clock cycles.

The raw level first passes through a short chain of flip-flops, so that the control logic and the window timer both see the same clocked copy. A one-bit Mealy controller holds the accepted level and drives the output straight from that bit. Whenever the clocked input agrees with the accepted level, the controller clears a free-running counter. The window ends when every counter bit is one, so the window is a power of two in length. With the default 18-bit counter at 50 MHz, the window is 262,144 cycles, or about 5.2 ms. A simulation can set the width as low as 4 bits. Every state of the controller can be reached and leads back to correct behaviour, so in hardware `rst_i` may be tied low.

Top module: `switch_debouncer`

## Requirements
- R1: While `rst_i` is high at a rising edge, the synchronizer, the counter and the accepted level all clear, and `level_o` reads 0 afterwards.
- R2: If `raw_i` takes a value different from `level_o` and then holds it, `level_o` takes the new value exactly SYNC_STAGES + 2^CNT_W rising edges after the first edge that samples the new value.
- R3: If `raw_i` goes back to the value of `level_o` before the window ends, `level_o` does not change and the window starts again from zero.
- R4: The window ends when all CNT_W counter bits are one. A raw level held for 2^CNT_W sampling edges is enough to change the output, and one held for 2^CNT_W - 1 edges is not. The counter reads zero in the cycle the output changes.
- R5: After an output change, another change needs a complete new window. Two changes are never closer together than 2^CNT_W cycles, even if the input bounces at once.
- R6: A bounce train whose steady stretches are all shorter than the window leaves `level_o` at its previous value.
- R7: Rising and falling changes follow the same rules and have the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high; may be tied low |
| raw_i | input | 1 | Asynchronous level from the switch contact |
| level_o | output | 1 | Debounced level; equals the controller state bit |

## Verification
An output change is due exactly SYNC_STAGES + 2^CNT_W rising edges after the edge that first samples a held new level. The bench counts edges from the moment it drives the input and samples one time unit after each edge, so each latency check lands in the cycle the change is due. The bench drives `raw_i` on falling edges. A reference model advances on rising edges, and the bench compares `level_o` with the model on every falling edge, so a result that comes early or late by even one cycle shows up as a mismatch. The cases with no effect (short pulses and bounce trains) are checked by watching `level_o` over a span longer than one full window.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  // Next accepted level: take the input when the window expires, else hold.
  function automatic logic next_level(input logic in_b, input logic done_b, input logic cur_b);
    return (in_b & done_b) | (cur_b & ~done_b);
  endfunction

  // Timer clear request: input agrees with the accepted level.
  function automatic logic match_clear(input logic in_b, input logic cur_b);
    return (~in_b & ~cur_b) | (in_b & cur_b);
  endfunction

endpackage

// File: rtl/db_sync.sv
module db_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) begin
            sr_q[i] <= sr_q[i-1];
          end
        end
      end
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/db_timer.sv
module db_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);

  // Increment, then force to zero by masking with the inverted clear.
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic clr);
    logic [CNT_W-1:0] inc;
    inc = c + {{(CNT_W-1){1'b0}}, 1'b1};
    return inc & {CNT_W{~clr}};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= step(cnt_q, clr_i);
  end

  assign done_o = &cnt_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/db_fsm.sv
module db_fsm
  import debounce_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic in_i,
  input  logic done_i,
  output logic state_o,
  output logic clr_o
);

  logic cur_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cur_q <= 1'b0;
    else       cur_q <= next_level(in_i, done_i, cur_q);
  end

  assign clr_o   = match_clear(in_i, cur_q);
  assign state_o = cur_q;

endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
  parameter int CNT_W       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic level_o
);

  // Named internal events, brought out for the checker.
  logic             sync_in;
  logic             tmr_clr;
  logic             tmr_done;
  logic [CNT_W-1:0] tmr_cnt;

  db_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_i),
    .q_o   (sync_in)
  );

  db_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (tmr_clr),
    .done_o (tmr_done),
    .cnt_o  (tmr_cnt)
  );

  db_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .in_i    (sync_in),
    .done_i  (tmr_done),
    .state_o (level_o),
    .clr_o   (tmr_clr)
  );

endmodule

// File: rtl/db_checker.sv
module db_checker #(
  parameter int CNT_W = 18
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             level_o,
  input logic             sync_in,
  input logic             tmr_done,
  input logic [CNT_W-1:0] tmr_cnt
);

  localparam logic [CNT_W:0] GAP_MIN = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [CNT_W:0] GAP_MAX = {(CNT_W+1){1'b1}};

  logic           lvl_q;
  logic [CNT_W:0] gap_q;
  logic           flip;

  assign flip = level_o != lvl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q <= 1'b0;
      gap_q <= '0;
    end else begin
      lvl_q <= level_o;
      if (flip)                 gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk_i)
    rst_i |=> (!level_o && tmr_cnt == '0));

  p_hold_without_done_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !tmr_done |=> $stable(level_o));

  p_clear_on_match_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (sync_in == level_o) |=> (tmr_cnt == '0));

  p_counter_zero_after_flip_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(level_o) |-> (tmr_cnt == '0));

  p_min_gap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    flip |-> (gap_q >= GAP_MIN));

endmodule

bind switch_debouncer db_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .level_o  (level_o),
  .sync_in  (sync_in),
  .tmr_done (tmr_done),
  .tmr_cnt  (tmr_cnt)
);

// File: tb/test_switch_debouncer.sv
module test_switch_debouncer;

  localparam int W    = 4;
  localparam int SYNC = 2;
  localparam int LIM  = 1 << W;
  localparam int LAT  = SYNC + LIM;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic raw_i = 1'b0;
  logic level_o;

  int total = 0;
  int bad = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  switch_debouncer #(.CNT_W(W), .SYNC_STAGES(SYNC)) i_switch_debouncer (
    .clk_i   (clk),
    .rst_i   (rst_i),
    .raw_i   (raw_i),
    .level_o (level_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: a run of disagreeing filtered samples of length LIM flips the level.
  logic [SYNC-1:0] m_sh;
  int m_run;
  logic m_exp;

  always @(posedge clk) begin
    if (rst_i) begin
      m_sh = '0; m_run = 0; m_exp = 1'b0;
    end else begin
      if (m_sh[SYNC-1] != m_exp) begin
        m_run++;
        if (m_run == LIM) begin
          m_exp = ~m_exp;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
      m_sh = {m_sh[SYNC-2:0], raw_i};
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst_i) check("R2 model compare", int'(level_o), int'(m_exp));
  end

  function automatic int edges_needed();
    return SYNC + LIM;
  endfunction

  // Drive raw at a falling edge, count rising edges until level_o equals target.
  task automatic measure(input logic val, output int n);
    @(negedge clk);
    raw_i = val;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (level_o != val && n < 4 * LAT);
  endtask

  task automatic watch_stable(input int cycles, input logic val, output bit ok);
    ok = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (level_o != val) ok = 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit ok;
    void'($urandom(32'd1234));
    raw_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 level after reset", int'(level_o), 0);
    raw_i = 1'b0;
    rst_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 level stays low after release", int'(level_o), 0);
    model_on = 1;

    // R2/R7 rising latency, R4 exact window length
    measure(1'b1, n);
    check("R2 R4 rise latency in edges", n, edges_needed());
    check("R7 rise reached", int'(level_o), 1);

    // R5: bounce back immediately after the flip needs a full new window
    measure(1'b0, n);
    check("R5 R7 fall latency right after a flip", n, edges_needed());
    check("R7 fall reached", int'(level_o), 0);

    // R3/R4: pulse one sample shorter than the window is ignored
    @(negedge clk);
    raw_i = 1'b1;
    repeat (LIM - 1) @(negedge clk);
    raw_i = 1'b0;
    watch_stable(3 * LAT, 1'b0, ok);
    check("R3 R4 short pulse leaves level low", int'(ok), 1);

    // R4: pulse of exactly the window length is accepted
    @(negedge clk);
    raw_i = 1'b1;
    repeat (LIM) @(negedge clk);
    raw_i = 1'b0;
    ok = 0;
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      if (level_o) ok = 1;
    end
    check("R4 full-window pulse reaches output", int'(ok), 1);
    repeat (2 * LAT) @(negedge clk);
    check("R4 level returns low afterwards", int'(level_o), 0);

    // R3: interrupted run restarts the window, high side
    measure(1'b1, n);
    check("R2 rise latency again", n, edges_needed());
    @(negedge clk);
    raw_i = 1'b0;
    repeat (LIM - 2) @(negedge clk);
    raw_i = 1'b1;
    @(negedge clk);
    raw_i = 1'b0;
    repeat (LIM - 2) @(negedge clk);
    raw_i = 1'b1;
    watch_stable(3 * LAT, 1'b1, ok);
    check("R3 R7 interrupted fall keeps level high", int'(ok), 1);

    // R6: bounce train with short steady stretches
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      raw_i = ~raw_i;
      repeat ($urandom_range(LIM - 2, 1)) @(negedge clk);
    end
    raw_i = 1'b1;
    watch_stable(2 * LAT, 1'b1, ok);
    check("R6 bounce train leaves level high", int'(ok), 1);

    // Random holds mixed with bounces; model compares every cycle
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      raw_i = 1'($urandom_range(1, 0));
      if ($urandom_range(3, 0) == 0) repeat ($urandom_range(3 * LAT, LAT)) @(negedge clk);
      else repeat ($urandom_range(LIM, 1)) @(negedge clk);
    end
    repeat (2 * LAT) @(negedge clk);
    check("R2 settled level follows input", int'(level_o), int'(raw_i));

    // R1 again: reset in the middle of operation
    @(negedge clk);
    model_on = 0;
    rst_i = 1'b1;
    raw_i = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset clears level", int'(level_o), 0);
    rst_i = 1'b0;
    model_on = 1;
    repeat (2 * LAT) @(negedge clk);
    check("R2 level rises after reset release", int'(level_o), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule